// File: doc/BRIEF.md
# Page Table Address Translator

This block turns virtual addresses into physical addresses through an on-chip page table. The table has one entry per virtual page and is indexed directly by the virtual page number, so no tag compare is needed. Each entry holds a present bit, a physical frame number, a disk sector handle, a referenced bit and a modified bit. A present entry yields a physical address built from the frame number and the unchanged page offset. An absent entry raises a page fault and reports the stored disk handle, so a fault handler knows where to fetch the page.

A command port lets a fault handler install a mapping, evict a mapping while recording its disk handle, clear every referenced bit at once, and read back the status of one entry. A replacement selector always offers an eviction candidate. It picks at random among present pages that have not been referenced since the last clear. If every present page has been referenced, it picks from all present pages. The candidate's modified bit tells the handler whether the page must be written back before its frame is reused. The disk transfer itself happens outside the block.

Top module: `ptw_translator`

## Requirements
- R1: After reset every entry is absent with referenced and modified bits at 0, `rsp_valid_o`, `stat_valid_o` and `victim_valid_o` are 0.
- R2: A request presented in one cycle gives `rsp_valid_o`=1 in the next cycle. On a present entry the response has `rsp_hit_o`=1, `rsp_fault_o`=0, and `rsp_pa_o` is the frame number above the request's low OFF_W address bits, passed through unchanged.
- R3: A request to an absent entry gives `rsp_fault_o`=1, `rsp_hit_o`=0 and `rsp_pa_o`=0, with `rsp_disk_o` set to the entry's stored disk handle. On a hit, `rsp_disk_o` is 0.
- R4: A request that hits sets the entry's referenced bit. A hitting request with `req_store_i`=1 also sets its modified bit. A faulting request changes no entry.
- R5: Command code 0 (install) makes the entry at `cmd_vpn_i` present with frame `cmd_ppn_i`, and clears its referenced and modified bits.
- R6: Command code 1 (evict) makes the entry absent, stores `cmd_disk_i` as its disk handle, and clears its referenced and modified bits.
- R7: Command code 2 clears every referenced bit in one cycle. A request that hits in that same cycle still leaves its own entry's referenced bit set.
- R8: Command code 3 (read) gives `stat_valid_o`=1 in the next cycle. `stat_present_o`, `stat_ref_o` and `stat_dirty_o` then show the entry as it stood before that clock edge.
- R9: `victim_valid_o` is 1 exactly when at least one entry is present. `victim_vpn_o` then names a present entry.
- R10: When any present entry has its referenced bit at 0, the candidate is one of those entries and `victim_unref_o`=1. Otherwise `victim_unref_o`=0. `victim_dirty_o` always equals the candidate's modified bit.
- R11: The candidate is chosen pseudo-randomly. With several unreferenced present pages and the table left unchanged, more than one distinct candidate appears over 64 cycles.
- R12: If an install and a request target the same entry in the same cycle, the response reflects the entry's old contents, and afterwards the entry holds the installed state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request strobe |
| req_va_i | input | VA_W | Virtual address |
| req_store_i | input | 1 | Request is a store |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 2 | 0 install, 1 evict, 2 clear referenced bits, 3 read status |
| cmd_vpn_i | input | VA_W-OFF_W | Target virtual page |
| cmd_ppn_i | input | PPN_W | Frame number for install |
| cmd_disk_i | input | DISK_W | Disk handle for evict |
| rsp_valid_o | output | 1 | Response strobe, one cycle after request |
| rsp_hit_o | output | 1 | Translation succeeded |
| rsp_fault_o | output | 1 | Page fault |
| rsp_pa_o | output | PPN_W+OFF_W | Physical address |
| rsp_disk_o | output | DISK_W | Disk handle on a fault |
| stat_valid_o | output | 1 | Read status strobe |
| stat_present_o | output | 1 | Entry present bit |
| stat_ref_o | output | 1 | Entry referenced bit |
| stat_dirty_o | output | 1 | Entry modified bit |
| victim_valid_o | output | 1 | A candidate exists |
| victim_vpn_o | output | VA_W-OFF_W | Candidate virtual page |
| victim_dirty_o | output | 1 | Candidate needs write-back |
| victim_unref_o | output | 1 | Candidate came from the unreferenced pool |

## Verification
Translation is driven with loads and stores to present pages, with requests to never-mapped and evicted pages, and with requests that coincide with installs or with a referenced-bit clear on the same entry. The hit cases show that the frame and offset are joined correctly. The fault cases show that the disk handle comes from the right entry. The coinciding cases show which update wins and that the response uses the old contents. A long stretch of mixed random traffic compares every response, status read and candidate against a behavioural table model. A quiet stretch with eight unreferenced pages shows that the candidate varies, and a fully referenced table shows the fallback.

// File: rtl/ptw_pkg.sv
`timescale 1ns/1ps
package ptw_pkg;
  typedef enum logic [1:0] {
    CMD_INSTALL = 2'd0,
    CMD_EVICT   = 2'd1,
    CMD_CLR_REF = 2'd2,
    CMD_READ    = 2'd3
  } cmd_e;
endpackage

// File: rtl/ptw_lfsr.sv
`timescale 1ns/1ps
module ptw_lfsr #(
  parameter int unsigned             W    = 12,
  parameter logic [W-1:0]            TAPS = 12'hE08,
  parameter logic [W-1:0]            SEED = 12'h5A3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] state_o
);
  logic [W-1:0] state_q;

  // Galois form, advances every cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEED;
    else         state_q <= {1'b0, state_q[W-1:1]} ^ (state_q[0] ? TAPS : '0);
  end

  assign state_o = state_q;
endmodule

// File: rtl/ptw_table.sv
`timescale 1ns/1ps
module ptw_table import ptw_pkg::*; #(
  parameter int unsigned VPN_W  = 6,
  parameter int unsigned PPN_W  = 4,
  parameter int unsigned DISK_W = 16
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [VPN_W-1:0]          lk_vpn_i,
  input  logic                      hit_i,
  input  logic                      store_i,
  input  logic                      cmd_valid_i,
  input  cmd_e                      cmd_op_i,
  input  logic [VPN_W-1:0]          cmd_vpn_i,
  input  logic [PPN_W-1:0]          cmd_ppn_i,
  input  logic [DISK_W-1:0]         cmd_disk_i,
  output logic                      lk_valid_o,
  output logic [PPN_W-1:0]          lk_ppn_o,
  output logic [DISK_W-1:0]         lk_disk_o,
  output logic                      rd_valid_o,
  output logic                      rd_ref_o,
  output logic                      rd_dirty_o,
  output logic [(1<<VPN_W)-1:0]     valid_vec_o,
  output logic [(1<<VPN_W)-1:0]     ref_vec_o,
  output logic [(1<<VPN_W)-1:0]     dirty_vec_o
);
  localparam int unsigned ENTRIES = 1 << VPN_W;

  logic [PPN_W-1:0]  ppn_arr  [ENTRIES];
  logic [DISK_W-1:0] disk_arr [ENTRIES];

  logic clr_all, do_install, do_evict;
  assign clr_all    = cmd_valid_i && (cmd_op_i == CMD_CLR_REF);
  assign do_install = cmd_valid_i && (cmd_op_i == CMD_INSTALL);
  assign do_evict   = cmd_valid_i && (cmd_op_i == CMD_EVICT);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic              v_q, r_q, d_q;
    logic [PPN_W-1:0]  p_q;
    logic [DISK_W-1:0] k_q;
    logic              sel_lk, sel_cmd;

    assign sel_lk  = hit_i && (lk_vpn_i == VPN_W'(g));
    assign sel_cmd = cmd_vpn_i == VPN_W'(g);

    // Later assignments win: clear, then hit, then install/evict
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q <= 1'b0;
        r_q <= 1'b0;
        d_q <= 1'b0;
        p_q <= '0;
        k_q <= '0;
      end else begin
        if (clr_all) r_q <= 1'b0;
        if (sel_lk) begin
          r_q <= 1'b1;
          if (store_i) d_q <= 1'b1;
        end
        if (sel_cmd && do_install) begin
          v_q <= 1'b1;
          p_q <= cmd_ppn_i;
          r_q <= 1'b0;
          d_q <= 1'b0;
        end else if (sel_cmd && do_evict) begin
          v_q <= 1'b0;
          k_q <= cmd_disk_i;
          r_q <= 1'b0;
          d_q <= 1'b0;
        end
      end
    end

    assign valid_vec_o[g] = v_q;
    assign ref_vec_o[g]   = r_q;
    assign dirty_vec_o[g] = d_q;
    assign ppn_arr[g]     = p_q;
    assign disk_arr[g]    = k_q;
  end

  assign lk_valid_o = valid_vec_o[lk_vpn_i];
  assign lk_ppn_o   = ppn_arr[lk_vpn_i];
  assign lk_disk_o  = disk_arr[lk_vpn_i];
  assign rd_valid_o = valid_vec_o[cmd_vpn_i];
  assign rd_ref_o   = ref_vec_o[cmd_vpn_i];
  assign rd_dirty_o = dirty_vec_o[cmd_vpn_i];
endmodule

// File: rtl/ptw_victim.sv
`timescale 1ns/1ps
module ptw_victim #(
  parameter int unsigned VPN_W  = 6,
  parameter int unsigned LFSR_W = 12
) (
  input  logic [(1<<VPN_W)-1:0] valid_i,
  input  logic [(1<<VPN_W)-1:0] ref_i,
  input  logic [(1<<VPN_W)-1:0] dirty_i,
  input  logic [LFSR_W-1:0]     rnd_i,
  output logic                  victim_valid_o,
  output logic [VPN_W-1:0]      victim_vpn_o,
  output logic                  victim_dirty_o,
  output logic                  victim_unref_o
);
  localparam int unsigned ENTRIES = 1 << VPN_W;

  logic [VPN_W-1:0] start;
  logic [VPN_W-1:0] pick_u, pick_a, idx;
  logic             found_u, found_a;

  // Fold the whole LFSR state into a scan start point
  always_comb begin
    start = '0;
    for (int b = 0; b < LFSR_W; b++) start[b % VPN_W] ^= rnd_i[b];
  end

  // Rotating first-match from the random start, two pools in parallel
  always_comb begin
    found_u = 1'b0;
    found_a = 1'b0;
    pick_u  = '0;
    pick_a  = '0;
    idx     = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      idx = start + VPN_W'(i);
      if (valid_i[idx] && !ref_i[idx] && !found_u) begin
        found_u = 1'b1;
        pick_u  = idx;
      end
      if (valid_i[idx] && !found_a) begin
        found_a = 1'b1;
        pick_a  = idx;
      end
    end
  end

  assign victim_valid_o = found_a;
  assign victim_unref_o = found_u;
  assign victim_vpn_o   = found_u ? pick_u : pick_a;
  assign victim_dirty_o = dirty_i[victim_vpn_o];
endmodule

// File: rtl/ptw_translator.sv
`timescale 1ns/1ps
module ptw_translator import ptw_pkg::*; #(
  parameter int unsigned           VA_W      = 20,
  parameter int unsigned           OFF_W     = 14,
  parameter int unsigned           PPN_W     = 4,
  parameter int unsigned           DISK_W    = 16,
  parameter int unsigned           LFSR_W    = 12,
  parameter logic [LFSR_W-1:0]     LFSR_TAPS = 12'hE08
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_valid_i,
  input  logic [VA_W-1:0]          req_va_i,
  input  logic                     req_store_i,
  input  logic                     cmd_valid_i,
  input  logic [1:0]               cmd_op_i,
  input  logic [VA_W-OFF_W-1:0]    cmd_vpn_i,
  input  logic [PPN_W-1:0]         cmd_ppn_i,
  input  logic [DISK_W-1:0]        cmd_disk_i,
  output logic                     rsp_valid_o,
  output logic                     rsp_hit_o,
  output logic                     rsp_fault_o,
  output logic [PPN_W+OFF_W-1:0]   rsp_pa_o,
  output logic [DISK_W-1:0]        rsp_disk_o,
  output logic                     stat_valid_o,
  output logic                     stat_present_o,
  output logic                     stat_ref_o,
  output logic                     stat_dirty_o,
  output logic                     victim_valid_o,
  output logic [VA_W-OFF_W-1:0]    victim_vpn_o,
  output logic                     victim_dirty_o,
  output logic                     victim_unref_o
);
  localparam int unsigned VPN_W   = VA_W - OFF_W;
  localparam int unsigned PA_W    = PPN_W + OFF_W;
  localparam int unsigned ENTRIES = 1 << VPN_W;

  cmd_e                 cmd_op;
  logic [VPN_W-1:0]     lk_vpn;
  logic                 lk_valid, hit_now;
  logic [PPN_W-1:0]     lk_ppn;
  logic [DISK_W-1:0]    lk_disk;
  logic                 rd_valid, rd_ref, rd_dirty;
  logic [ENTRIES-1:0]   valid_vec, ref_vec, dirty_vec;
  logic [LFSR_W-1:0]    rnd;

  assign cmd_op  = cmd_e'(cmd_op_i);
  assign lk_vpn  = req_va_i[VA_W-1:OFF_W];
  assign hit_now = req_valid_i && lk_valid;

  ptw_table #(.VPN_W(VPN_W), .PPN_W(PPN_W), .DISK_W(DISK_W)) u_table (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lk_vpn_i    (lk_vpn),
    .hit_i       (hit_now),
    .store_i     (req_store_i),
    .cmd_valid_i (cmd_valid_i),
    .cmd_op_i    (cmd_op),
    .cmd_vpn_i   (cmd_vpn_i),
    .cmd_ppn_i   (cmd_ppn_i),
    .cmd_disk_i  (cmd_disk_i),
    .lk_valid_o  (lk_valid),
    .lk_ppn_o    (lk_ppn),
    .lk_disk_o   (lk_disk),
    .rd_valid_o  (rd_valid),
    .rd_ref_o    (rd_ref),
    .rd_dirty_o  (rd_dirty),
    .valid_vec_o (valid_vec),
    .ref_vec_o   (ref_vec),
    .dirty_vec_o (dirty_vec)
  );

  ptw_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS)) u_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .state_o (rnd)
  );

  ptw_victim #(.VPN_W(VPN_W), .LFSR_W(LFSR_W)) u_victim (
    .valid_i        (valid_vec),
    .ref_i          (ref_vec),
    .dirty_i        (dirty_vec),
    .rnd_i          (rnd),
    .victim_valid_o (victim_valid_o),
    .victim_vpn_o   (victim_vpn_o),
    .victim_dirty_o (victim_dirty_o),
    .victim_unref_o (victim_unref_o)
  );

  // Response stage: sampled from the table before this edge's update
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_fault_o <= 1'b0;
      rsp_pa_o    <= '0;
      rsp_disk_o  <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_hit_o   <= hit_now;
      rsp_fault_o <= req_valid_i && !lk_valid;
      rsp_pa_o    <= hit_now ? {lk_ppn, req_va_i[OFF_W-1:0]} : '0;
      rsp_disk_o  <= (req_valid_i && !lk_valid) ? lk_disk : '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_valid_o   <= 1'b0;
      stat_present_o <= 1'b0;
      stat_ref_o     <= 1'b0;
      stat_dirty_o   <= 1'b0;
    end else begin
      stat_valid_o   <= cmd_valid_i && (cmd_op == CMD_READ);
      stat_present_o <= rd_valid;
      stat_ref_o     <= rd_ref;
      stat_dirty_o   <= rd_dirty;
    end
  end

  logic [PA_W-1:0] unused_pa_w;
  assign unused_pa_w = '0;
endmodule

// File: rtl/ptw_checker.sv
`timescale 1ns/1ps
module ptw_checker #(
  parameter int unsigned VA_W  = 20,
  parameter int unsigned OFF_W = 14,
  parameter int unsigned PPN_W = 4
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   req_valid_i,
  input logic [VA_W-1:0]        req_va_i,
  input logic                   cmd_valid_i,
  input logic [1:0]             cmd_op_i,
  input logic                   rsp_valid_o,
  input logic                   rsp_hit_o,
  input logic                   rsp_fault_o,
  input logic [PPN_W+OFF_W-1:0] rsp_pa_o,
  input logic                   stat_valid_o,
  input logic                   victim_valid_o,
  input logic                   victim_unref_o
);
  p_rsp_follows_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  p_no_spurious_rsp_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);
  p_offset_kept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (rsp_fault_o || rsp_pa_o[OFF_W-1:0] == $past(req_va_i[OFF_W-1:0])));
  p_hit_xor_fault_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rsp_hit_o != rsp_fault_o));
  p_idle_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> (!rsp_hit_o && !rsp_fault_o));
  p_fault_no_pa_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_fault_o |-> (rsp_pa_o == '0));
  p_read_answers_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == 2'd3) |=> stat_valid_o);
  p_unref_needs_valid_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    victim_unref_o |-> victim_valid_o);
endmodule

bind ptw_translator ptw_checker #(.VA_W(VA_W), .OFF_W(OFF_W), .PPN_W(PPN_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .req_valid_i    (req_valid_i),
  .req_va_i       (req_va_i),
  .cmd_valid_i    (cmd_valid_i),
  .cmd_op_i       (cmd_op_i),
  .rsp_valid_o    (rsp_valid_o),
  .rsp_hit_o      (rsp_hit_o),
  .rsp_fault_o    (rsp_fault_o),
  .rsp_pa_o       (rsp_pa_o),
  .stat_valid_o   (stat_valid_o),
  .victim_valid_o (victim_valid_o),
  .victim_unref_o (victim_unref_o)
);

// File: tb/sim_ptw_translator.sv
`timescale 1ns/1ps
module sim_ptw_translator;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [19:0] req_va_i = '0;
  logic        req_store_i = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic [1:0]  cmd_op_i = '0;
  logic [5:0]  cmd_vpn_i = '0;
  logic [3:0]  cmd_ppn_i = '0;
  logic [15:0] cmd_disk_i = '0;
  logic        rsp_valid_o, rsp_hit_o, rsp_fault_o;
  logic [17:0] rsp_pa_o;
  logic [15:0] rsp_disk_o;
  logic        stat_valid_o, stat_present_o, stat_ref_o, stat_dirty_o;
  logic        victim_valid_o, victim_dirty_o, victim_unref_o;
  logic [5:0]  victim_vpn_o;

  always #2 clk_i = ~clk_i;

  ptw_translator u0 (.*);

  int errors = 0;
  int checks = 0;

  bit          m_v [64];
  bit          m_r [64];
  bit          m_d [64];
  logic [3:0]  m_p [64];
  logic [15:0] m_k [64];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_victim();
    bit any_v = 0, any_u = 0;
    for (int i = 0; i < 64; i++) begin
      if (m_v[i]) any_v = 1;
      if (m_v[i] && !m_r[i]) any_u = 1;
    end
    chk(victim_valid_o == any_v, "R9", "victim_valid", victim_valid_o, any_v);
    chk(victim_unref_o == any_u, "R10", "victim_unref", victim_unref_o, any_u);
    if (victim_valid_o) begin
      chk(m_v[victim_vpn_o], "R9", "victim present", m_v[victim_vpn_o], 1);
      if (any_u) chk(!m_r[victim_vpn_o], "R10", "victim ref", m_r[victim_vpn_o], 0);
      chk(victim_dirty_o == m_d[victim_vpn_o], "R10", "victim dirty",
          victim_dirty_o, m_d[victim_vpn_o]);
    end
  endtask

  task automatic cyc(input bit rv, input logic [19:0] va, input bit st,
                     input bit cv, input logic [1:0] op, input logic [5:0] vpn,
                     input logic [3:0] ppn, input logic [15:0] dk);
    int lv;
    bit e_hit, e_flt, e_sv, e_sp, e_sr, e_sd;
    logic [17:0] e_pa;
    logic [15:0] e_dk;
    @(negedge clk_i);
    req_valid_i = rv; req_va_i = va; req_store_i = st;
    cmd_valid_i = cv; cmd_op_i = op; cmd_vpn_i = vpn; cmd_ppn_i = ppn; cmd_disk_i = dk;
    lv = va[19:14];
    e_hit = rv && m_v[lv];
    e_flt = rv && !m_v[lv];
    e_pa  = e_hit ? {m_p[lv], va[13:0]} : 18'h0;
    e_dk  = e_flt ? m_k[lv] : 16'h0;
    e_sv  = cv && op == 2'd3;
    e_sp  = m_v[vpn]; e_sr = m_r[vpn]; e_sd = m_d[vpn];
    // model update, newest wins
    if (cv && op == 2'd2) for (int i = 0; i < 64; i++) m_r[i] = 0;
    if (e_hit) begin m_r[lv] = 1; if (st) m_d[lv] = 1; end
    if (cv && op == 2'd0) begin m_v[vpn] = 1; m_p[vpn] = ppn; m_r[vpn] = 0; m_d[vpn] = 0; end
    if (cv && op == 2'd1) begin m_v[vpn] = 0; m_k[vpn] = dk; m_r[vpn] = 0; m_d[vpn] = 0; end
    @(posedge clk_i); #1;
    chk(rsp_valid_o == rv, "R2", "rsp_valid", rsp_valid_o, rv);
    if (rv) begin
      chk(rsp_hit_o == e_hit, "R2", "hit", rsp_hit_o, e_hit);
      chk(rsp_fault_o == e_flt, "R3", "fault", rsp_fault_o, e_flt);
      chk(rsp_pa_o == e_pa, "R2", "pa", rsp_pa_o, e_pa);
      chk(rsp_disk_o == e_dk, "R3", "disk", rsp_disk_o, e_dk);
    end
    chk(stat_valid_o == e_sv, "R8", "stat_valid", stat_valid_o, e_sv);
    if (e_sv) begin
      chk(stat_present_o == e_sp, "R8", "stat_present", stat_present_o, e_sp);
      chk(stat_ref_o == e_sr, "R8", "stat_ref", stat_ref_o, e_sr);
      chk(stat_dirty_o == e_sd, "R8", "stat_dirty", stat_dirty_o, e_sd);
    end
    check_victim();
    req_valid_i = 0; cmd_valid_i = 0;
  endtask

  task automatic tr(input logic [19:0] va, input bit st);
    cyc(1, va, st, 0, 2'd0, 6'd0, 4'd0, 16'd0);
  endtask
  task automatic cmd(input logic [1:0] op, input logic [5:0] vpn,
                     input logic [3:0] ppn, input logic [15:0] dk);
    cyc(0, 20'd0, 0, 1, op, vpn, ppn, dk);
  endtask
  task automatic rd(input logic [5:0] vpn);
    cmd(2'd3, vpn, 4'd0, 16'd0);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit seen [64];
    int distinct;
    for (int i = 0; i < 64; i++) begin m_v[i] = 0; m_r[i] = 0; m_d[i] = 0; m_p[i] = 0; m_k[i] = 0; end
    repeat (3) @(posedge clk_i);
    @(negedge clk_i); rst_ni = 1;
    #1;
    // R1 reset state
    chk(rsp_valid_o == 0, "R1", "rsp_valid after reset", rsp_valid_o, 0);
    chk(stat_valid_o == 0, "R1", "stat_valid after reset", stat_valid_o, 0);
    chk(victim_valid_o == 0, "R1", "victim_valid after reset", victim_valid_o, 0);
    rd(6'd5);                                    // R1 entry absent, bits clear
    tr(20'h0ABCD, 0);                            // R3 fault with zero handle
    // R6 evict stores handle, R3 reports it
    cmd(2'd1, 6'd6, 4'd0, 16'h1239);
    tr({6'd6, 14'h0123}, 0);
    // R5 install, R2 hit, R4 ref/dirty
    cmd(2'd0, 6'd2, 4'b0010, 16'd0);
    cmd(2'd0, 6'd5, 4'b1010, 16'd0);
    cmd(2'd0, 6'd7, 4'b0001, 16'd0);
    tr(20'b000010_00110010101010, 0);
    rd(6'd2);
    tr({6'd5, 14'h3FFF}, 1);
    rd(6'd5);
    tr({6'd7, 14'h0000}, 1);
    tr({6'd6, 14'h2000}, 1);                     // R4 fault leaves entry alone
    rd(6'd6);
    // R5 reinstall clears dirty
    cmd(2'd0, 6'd5, 4'b1011, 16'd0);
    rd(6'd5);
    // R7 clear with simultaneous hit on entry 2
    cyc(1, {6'd2, 14'h0001}, 0, 1, 2'd2, 6'd0, 4'd0, 16'd0);
    rd(6'd2);
    rd(6'd7);
    // R12 install and translate same entry
    cyc(1, {6'd7, 14'h0055}, 1, 1, 2'd0, 6'd7, 4'b1100, 16'd0);
    rd(6'd7);
    tr({6'd7, 14'h0055}, 0);
    // R11 several unreferenced pages, quiet table
    for (int i = 10; i < 18; i++) cmd(2'd0, 6'(i), 4'(i), 16'd0);
    for (int i = 0; i < 64; i++) seen[i] = 0;
    distinct = 0;
    for (int c = 0; c < 64; c++) begin
      cyc(0, 20'd0, 0, 0, 2'd0, 6'd0, 4'd0, 16'd0);
      if (!seen[victim_vpn_o]) begin seen[victim_vpn_o] = 1; distinct++; end
    end
    chk(distinct > 1, "R11", "distinct candidates", distinct, 2);
    // R10 fallback: touch every present page
    for (int i = 0; i < 64; i++) if (m_v[i]) tr({6'(i), 14'h0}, 0);
    chk(victim_unref_o == 0, "R10", "fallback unref flag", victim_unref_o, 0);
    // mixed random traffic
    for (int c = 0; c < 3000; c++) begin
      cyc($urandom_range(0, 1), 20'($urandom), 1'($urandom),
          ($urandom_range(0, 3) == 0), 2'($urandom), 6'($urandom),
          4'($urandom), 16'($urandom));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule